// File: doc/BRIEF.md
# I2C Interrupt Request Flag Controller

This block keeps the single interrupt request flag of an I2C controller. The bus engine reports events to it as one-cycle pulses: start and stop detection, a byte loaded into the transmit shift register, a byte moved into the receive data register, the acknowledge bit sampled after a byte, wait insertion, arbitration loss, and the result of decoding the first frame after a start. The engine also supplies the current role (master or slave), the direction (transmit or receive) and the buffer status levels. Configuration bits decide which of those events are allowed to raise the flag.

Any qualified event sets one sticky flag. The flag stays set until software writes 0 to it through a register write port. The interrupt line to the CPU is the flag gated by a module-level enable. The block also holds one address-match status bit for each programmed slave address and a general-call status bit. These bits record why a slave-mode address interrupt was raised.

Top module: `i2c_irq_flag_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no event, flag_o, irq_o, every bit of addr_stat_o and gcall_stat_o are 0.
- R2: In transmit mode (tx_mode_i=1), start_det_i with tx_empty_i=1 sets the flag one clock later. In receive mode, or with tx_empty_i=0, it does not.
- R3: In transmit mode, tx_load_i with tx_empty_i=1 sets the flag. With tx_empty_i=0 or in receive mode it does not.
- R4: In receive mode (tx_mode_i=0), rx_load_i with rx_full_i=1 sets the flag. With rx_full_i=0 or in transmit mode it does not.
- R5: In transmit mode with ack_chk_en_i=1, ack_done_i with ack_bit_i=1 (NACK) sets the flag. An ack_bit_i of 0, or ack_chk_en_i=0, leaves it clear.
- R6: In master mode (master_i=1) with wait_en_i=1, wait_ins_i sets the flag. It has no effect in slave mode or with wait_en_i=0.
- R7: In master mode, arb_lost_i sets the flag only when arb_irq_en_i=1.
- R8: In slave mode, addr_frame_i with addr_hit_i[k]=1 sets the flag and addr_stat_o[k]. Bit k stands for slave address k. A later start_det_i without addr_frame_i clears every addr_stat_o bit.
- R9: In slave mode with fmt_sel_i=0, addr_frame_i with gen_call_i=1 sets the flag and gcall_stat_o. With fmt_sel_i=1 neither is set. A later start_det_i without addr_frame_i clears gcall_stat_o.
- R10: In slave mode, stop_det_i sets the flag only when stop_mask_i=0.
- R11: A write (wr_en_i=1) with wr_data_i=0 clears the flag one clock later. A write with wr_data_i=1 leaves the flag unchanged.
- R12: When a set condition and a clearing write occur in the same cycle, the flag is 1 after that clock.
- R13: irq_o is 1 exactly when the flag is 1 and irq_en_i=1. The flag itself is not affected by irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| tx_mode_i | input | 1 | 1 = transmit direction, 0 = receive |
| tx_empty_i | input | 1 | Transmit data register empty status |
| rx_full_i | input | 1 | Receive data register full status |
| ack_chk_en_i | input | 1 | Enable NACK interrupt after transmitted bytes |
| wait_en_i | input | 1 | Wait insertion mode enable |
| arb_irq_en_i | input | 1 | Arbitration-lost interrupt enable |
| fmt_sel_i | input | 1 | Format select, 0 = I2C format (general call decoded) |
| stop_mask_i | input | 1 | 1 masks the stop-detected interrupt |
| irq_en_i | input | 1 | Module interrupt enable |
| start_det_i | input | 1 | Start condition detected pulse |
| stop_det_i | input | 1 | Stop condition detected pulse |
| tx_load_i | input | 1 | Transmit byte moved into shift register pulse |
| rx_load_i | input | 1 | Received byte moved into receive register pulse |
| ack_done_i | input | 1 | Acknowledge bit sampled after a transmitted byte |
| ack_bit_i | input | 1 | Sampled acknowledge value, 1 = NACK |
| wait_ins_i | input | 1 | Wait inserted between data and acknowledge pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| addr_frame_i | input | 1 | First frame after start has been decoded |
| addr_hit_i | input | NUM_SADDR | Per slave address match of that frame |
| gen_call_i | input | 1 | That frame is the general call address |
| wr_en_i | input | 1 | Software write to the flag |
| wr_data_i | input | 1 | Written flag value (only 0 acts) |
| flag_o | output | 1 | Interrupt request flag |
| irq_o | output | 1 | Interrupt request to the CPU |
| addr_stat_o | output | NUM_SADDR | Address-match status per slave address |
| gcall_stat_o | output | 1 | General-call status |

## Verification
On every cycle, the assertions check these rules: any qualified event raises the flag on the next clock, and the priority of a set over a clearing write holds. They also check that a write of 1 or an idle cycle never changes the flag, that irq_o never rises without the flag, and that a general-call status is only raised when the I2C format was selected. Some behaviour is shown only by the bench scenarios: that events are rejected in the wrong role or direction, or with their enable off. The same holds for the per-address split of the match status and its clearing by the next start. The bench also runs a long random stream and compares it against a behavioural model on every clock.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  // one bit per interrupt reason
  typedef enum int unsigned {
    RSN_START  = 0,
    RSN_TXLOAD = 1,
    RSN_RXLOAD = 2,
    RSN_NACK   = 3,
    RSN_WAIT   = 4,
    RSN_ARB    = 5,
    RSN_MATCH  = 6,
    RSN_GCALL  = 7,
    RSN_STOP   = 8
  } reason_e;

  localparam int unsigned NUM_REASON = 9;
  typedef logic [NUM_REASON-1:0] reason_vec_t;

  typedef struct packed {
    logic master;
    logic tx_mode;
    logic tx_empty;
    logic rx_full;
  } bus_state_t;

  typedef struct packed {
    logic ack_chk_en;
    logic wait_en;
    logic arb_irq_en;
    logic fmt_sel;
    logic stop_mask;
  } irq_cfg_t;
endpackage

// File: rtl/i2c_irq_cond.sv
module i2c_irq_cond
  import i2c_irq_pkg::*;
#(
  parameter int unsigned NUM_SADDR = 2
) (
  input  bus_state_t            bus_i,
  input  irq_cfg_t              cfg_i,
  input  logic                  start_det_i,
  input  logic                  stop_det_i,
  input  logic                  tx_load_i,
  input  logic                  rx_load_i,
  input  logic                  ack_done_i,
  input  logic                  ack_bit_i,
  input  logic                  wait_ins_i,
  input  logic                  arb_lost_i,
  input  logic                  addr_frame_i,
  input  logic [NUM_SADDR-1:0]  addr_hit_i,
  input  logic                  gen_call_i,
  output reason_vec_t           reason_o,
  output logic [NUM_SADDR-1:0]  hit_set_o,
  output logic                  gcall_set_o
);
  logic slave_frame;
  logic txm, rxm, slv;

  assign txm         = bus_i.tx_mode;
  assign rxm         = ~bus_i.tx_mode;
  assign slv         = ~bus_i.master;
  assign slave_frame = slv & addr_frame_i;

  for (genvar k = 0; k < NUM_SADDR; k++) begin : g_hit
    assign hit_set_o[k] = slave_frame & addr_hit_i[k];
  end

  // general call only decoded in I2C format
  assign gcall_set_o = slave_frame & gen_call_i & ~cfg_i.fmt_sel;

  always_comb begin
    reason_o             = '0;
    reason_o[RSN_START]  = txm & start_det_i & bus_i.tx_empty;
    reason_o[RSN_TXLOAD] = txm & tx_load_i & bus_i.tx_empty;
    reason_o[RSN_RXLOAD] = rxm & rx_load_i & bus_i.rx_full;
    reason_o[RSN_NACK]   = txm & cfg_i.ack_chk_en & ack_done_i & ack_bit_i;
    reason_o[RSN_WAIT]   = bus_i.master & cfg_i.wait_en & wait_ins_i;
    reason_o[RSN_ARB]    = bus_i.master & cfg_i.arb_irq_en & arb_lost_i;
    reason_o[RSN_MATCH]  = |hit_set_o;
    reason_o[RSN_GCALL]  = gcall_set_o;
    reason_o[RSN_STOP]   = slv & stop_det_i & ~cfg_i.stop_mask;
  end
endmodule

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky
  import i2c_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  reason_vec_t reason_i,
  input  logic        wr_en_i,
  input  logic        wr_data_i,
  output logic        flag_o
);
  logic set_any, sw_clr;

  assign set_any = |reason_i;
  assign sw_clr  = wr_en_i & ~wr_data_i;

  // set has priority over clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_any) flag_o <= 1'b1;
    else if (sw_clr)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_irq_addr_stat.sv
module i2c_irq_addr_stat #(
  parameter int unsigned NUM_SADDR = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_det_i,
  input  logic [NUM_SADDR-1:0] hit_set_i,
  input  logic                 gcall_set_i,
  output logic [NUM_SADDR-1:0] addr_stat_o,
  output logic                 gcall_stat_o
);
  for (genvar k = 0; k < NUM_SADDR; k++) begin : g_stat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           addr_stat_o[k] <= 1'b0;
      else if (hit_set_i[k]) addr_stat_o[k] <= 1'b1;
      else if (start_det_i)  addr_stat_o[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gcall_stat_o <= 1'b0;
    else if (gcall_set_i) gcall_stat_o <= 1'b1;
    else if (start_det_i) gcall_stat_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_irq_flag_ctrl.sv
module i2c_irq_flag_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned NUM_SADDR = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 master_i,
  input  logic                 tx_mode_i,
  input  logic                 tx_empty_i,
  input  logic                 rx_full_i,
  input  logic                 ack_chk_en_i,
  input  logic                 wait_en_i,
  input  logic                 arb_irq_en_i,
  input  logic                 fmt_sel_i,
  input  logic                 stop_mask_i,
  input  logic                 irq_en_i,
  input  logic                 start_det_i,
  input  logic                 stop_det_i,
  input  logic                 tx_load_i,
  input  logic                 rx_load_i,
  input  logic                 ack_done_i,
  input  logic                 ack_bit_i,
  input  logic                 wait_ins_i,
  input  logic                 arb_lost_i,
  input  logic                 addr_frame_i,
  input  logic [NUM_SADDR-1:0] addr_hit_i,
  input  logic                 gen_call_i,
  input  logic                 wr_en_i,
  input  logic                 wr_data_i,
  output logic                 flag_o,
  output logic                 irq_o,
  output logic [NUM_SADDR-1:0] addr_stat_o,
  output logic                 gcall_stat_o
);
  bus_state_t           bus;
  irq_cfg_t             cfg;
  reason_vec_t          reason;
  logic [NUM_SADDR-1:0] hit_set;
  logic                 gcall_set;

  assign bus = '{master: master_i, tx_mode: tx_mode_i,
                 tx_empty: tx_empty_i, rx_full: rx_full_i};
  assign cfg = '{ack_chk_en: ack_chk_en_i, wait_en: wait_en_i,
                 arb_irq_en: arb_irq_en_i, fmt_sel: fmt_sel_i,
                 stop_mask: stop_mask_i};

  i2c_irq_cond #(.NUM_SADDR(NUM_SADDR)) u_cond (
    .bus_i        (bus),
    .cfg_i        (cfg),
    .start_det_i  (start_det_i),
    .stop_det_i   (stop_det_i),
    .tx_load_i    (tx_load_i),
    .rx_load_i    (rx_load_i),
    .ack_done_i   (ack_done_i),
    .ack_bit_i    (ack_bit_i),
    .wait_ins_i   (wait_ins_i),
    .arb_lost_i   (arb_lost_i),
    .addr_frame_i (addr_frame_i),
    .addr_hit_i   (addr_hit_i),
    .gen_call_i   (gen_call_i),
    .reason_o     (reason),
    .hit_set_o    (hit_set),
    .gcall_set_o  (gcall_set)
  );

  i2c_irq_sticky u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reason_i  (reason),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .flag_o    (flag_o)
  );

  i2c_irq_addr_stat #(.NUM_SADDR(NUM_SADDR)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_det_i  (start_det_i),
    .hit_set_i    (hit_set),
    .gcall_set_i  (gcall_set),
    .addr_stat_o  (addr_stat_o),
    .gcall_stat_o (gcall_stat_o)
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/i2c_irq_flag_chk.sv
module i2c_irq_flag_chk #(
  parameter int unsigned NUM_SADDR = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 master_i,
  input logic                 tx_mode_i,
  input logic                 tx_empty_i,
  input logic                 rx_full_i,
  input logic                 ack_chk_en_i,
  input logic                 wait_en_i,
  input logic                 arb_irq_en_i,
  input logic                 fmt_sel_i,
  input logic                 stop_mask_i,
  input logic                 irq_en_i,
  input logic                 start_det_i,
  input logic                 stop_det_i,
  input logic                 tx_load_i,
  input logic                 rx_load_i,
  input logic                 ack_done_i,
  input logic                 ack_bit_i,
  input logic                 wait_ins_i,
  input logic                 arb_lost_i,
  input logic                 addr_frame_i,
  input logic [NUM_SADDR-1:0] addr_hit_i,
  input logic                 gen_call_i,
  input logic                 wr_en_i,
  input logic                 wr_data_i,
  input logic                 flag_o,
  input logic                 irq_o,
  input logic [NUM_SADDR-1:0] addr_stat_o,
  input logic                 gcall_stat_o
);
  logic tx_ev, mst_ev, slv_ev, any_ev;

  assign tx_ev  = tx_mode_i & ((start_det_i & tx_empty_i) | (tx_load_i & tx_empty_i)
                | (ack_chk_en_i & ack_done_i & ack_bit_i));
  assign mst_ev = master_i & ((wait_en_i & wait_ins_i) | (arb_irq_en_i & arb_lost_i));
  assign slv_ev = ~master_i & ((addr_frame_i & (|addr_hit_i))
                | (addr_frame_i & gen_call_i & ~fmt_sel_i) | (stop_det_i & ~stop_mask_i));
  assign any_ev = tx_ev | mst_ev | slv_ev | (~tx_mode_i & rx_load_i & rx_full_i);

  // R12
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ev |=> flag_o);

  // R11
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i && !any_ev) |=> !flag_o);

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_ev && !(wr_en_i && !wr_data_i)) |=> $stable(flag_o));

  // R13
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));

  // R9
  gcall_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gcall_stat_o) |-> $past(!fmt_sel_i && !master_i));

  // R8
  stat_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(addr_stat_o & ~$past(addr_stat_o)) != 0) |-> $past(addr_frame_i) && flag_o);
endmodule

bind i2c_irq_flag_ctrl i2c_irq_flag_chk #(.NUM_SADDR(NUM_SADDR)) chk_i (.*);

// File: tb/i2c_irq_flag_ctrl_tb_top.sv
module i2c_irq_flag_ctrl_tb_top;
  localparam int N = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i, tx_mode_i, tx_empty_i, rx_full_i;
  logic ack_chk_en_i, wait_en_i, arb_irq_en_i, fmt_sel_i, stop_mask_i, irq_en_i;
  logic start_det_i, stop_det_i, tx_load_i, rx_load_i, ack_done_i, ack_bit_i;
  logic wait_ins_i, arb_lost_i, addr_frame_i, gen_call_i, wr_en_i, wr_data_i;
  logic [N-1:0] addr_hit_i;
  logic flag_o, irq_o, gcall_stat_o;
  logic [N-1:0] addr_stat_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference state
  bit m_flag;
  bit m_gc;
  bit m_st[N];

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  i2c_irq_flag_ctrl #(.NUM_SADDR(N)) dut_i (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_ev();
    start_det_i = 0; stop_det_i = 0; tx_load_i = 0; rx_load_i = 0;
    ack_done_i = 0; ack_bit_i = 0; wait_ins_i = 0; arb_lost_i = 0;
    addr_frame_i = 0; addr_hit_i = '0; gen_call_i = 0; wr_en_i = 0; wr_data_i = 0;
  endtask

  task automatic set_mode(bit mst, bit tx);
    master_i = mst; tx_mode_i = tx;
  endtask

  // compare every output with the model
  task automatic compare(string tag);
    chk(tag, "flag", flag_o, m_flag);
    chk(tag, "irq", irq_o, (m_flag && irq_en_i) ? 1 : 0);
    chk(tag, "gcall", gcall_stat_o, m_gc);
    for (int k = 0; k < N; k++) chk(tag, "addr_stat", addr_stat_o[k], m_st[k]);
  endtask

  // model step from inputs present before the edge, then compare at negedge
  task automatic cyc(string tag);
    bit ev, sl, gcs;
    bit hits[N];
    sl = !master_i;
    ev = 0;
    if (tx_mode_i == 1 && tx_empty_i == 1 && (start_det_i || tx_load_i)) ev = 1;
    if (tx_mode_i == 0 && rx_full_i == 1 && rx_load_i) ev = 1;
    if (tx_mode_i == 1 && ack_chk_en_i && ack_done_i && ack_bit_i) ev = 1;
    if (master_i && wait_en_i && wait_ins_i) ev = 1;
    if (master_i && arb_irq_en_i && arb_lost_i) ev = 1;
    if (sl && stop_det_i && !stop_mask_i) ev = 1;
    for (int k = 0; k < N; k++) begin
      hits[k] = sl && addr_frame_i && addr_hit_i[k];
      if (hits[k]) ev = 1;
    end
    gcs = sl && addr_frame_i && gen_call_i && !fmt_sel_i;
    if (gcs) ev = 1;
    @(posedge clk_i);
    if (ev) m_flag = 1;
    else if (wr_en_i && !wr_data_i) m_flag = 0;
    for (int k = 0; k < N; k++)
      if (hits[k]) m_st[k] = 1; else if (start_det_i) m_st[k] = 0;
    if (gcs) m_gc = 1; else if (start_det_i) m_gc = 0;
    @(negedge clk_i);
    compare(tag);
    idle_ev();
  endtask

  task automatic clear_flag();
    wr_en_i = 1; wr_data_i = 0; cyc("R11");
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    idle_ev();
    set_mode(0, 0);
    tx_empty_i = 0; rx_full_i = 0; ack_chk_en_i = 0; wait_en_i = 0;
    arb_irq_en_i = 0; fmt_sel_i = 0; stop_mask_i = 0; irq_en_i = 1;
    m_flag = 0; m_gc = 0;
    for (int k = 0; k < N; k++) m_st[k] = 0;
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    cyc("R1");

    // R2 transmit start
    set_mode(1, 1); tx_empty_i = 1; start_det_i = 1; cyc("R2");
    clear_flag();
    set_mode(1, 0); start_det_i = 1; cyc("R2");
    set_mode(1, 1); tx_empty_i = 0; start_det_i = 1; cyc("R2");
    // R3 tx load
    tx_empty_i = 1; tx_load_i = 1; cyc("R3");
    clear_flag();
    tx_empty_i = 0; tx_load_i = 1; cyc("R3");
    set_mode(1, 0); tx_empty_i = 1; tx_load_i = 1; cyc("R3");
    // R4 receive load
    rx_full_i = 1; rx_load_i = 1; cyc("R4");
    clear_flag();
    rx_full_i = 0; rx_load_i = 1; cyc("R4");
    set_mode(0, 1); rx_full_i = 1; rx_load_i = 1; cyc("R4");
    // R5 NACK
    ack_chk_en_i = 1; ack_done_i = 1; ack_bit_i = 1; cyc("R5");
    clear_flag();
    ack_done_i = 1; ack_bit_i = 0; cyc("R5");
    ack_chk_en_i = 0; ack_done_i = 1; ack_bit_i = 1; cyc("R5");
    // R6 wait
    set_mode(1, 0); wait_en_i = 1; wait_ins_i = 1; cyc("R6");
    clear_flag();
    wait_en_i = 0; wait_ins_i = 1; cyc("R6");
    set_mode(0, 0); wait_en_i = 1; wait_ins_i = 1; cyc("R6");
    wait_en_i = 0;
    // R7 arbitration
    set_mode(1, 1); tx_empty_i = 0; arb_lost_i = 1; cyc("R7");
    arb_irq_en_i = 1; arb_lost_i = 1; cyc("R7");
    clear_flag();
    // R8 address match per index
    set_mode(0, 0); addr_frame_i = 1; addr_hit_i = 2'b10; cyc("R8");
    clear_flag();
    addr_frame_i = 1; addr_hit_i = 2'b01; cyc("R8");
    start_det_i = 1; cyc("R8");
    clear_flag();
    // R9 general call
    addr_frame_i = 1; gen_call_i = 1; cyc("R9");
    clear_flag();
    start_det_i = 1; cyc("R9");
    fmt_sel_i = 1; addr_frame_i = 1; gen_call_i = 1; cyc("R9");
    fmt_sel_i = 0;
    // R10 stop
    stop_mask_i = 1; stop_det_i = 1; cyc("R10");
    stop_mask_i = 0; stop_det_i = 1; cyc("R10");
    // R11 write 1 no effect, then clear
    wr_en_i = 1; wr_data_i = 1; cyc("R11");
    clear_flag();
    wr_en_i = 1; wr_data_i = 1; cyc("R11");
    // R12 set and clear same cycle
    stop_det_i = 1; wr_en_i = 1; wr_data_i = 0; cyc("R12");
    // R13 enable gating
    irq_en_i = 0; cyc("R13");
    irq_en_i = 1; cyc("R13");

    // random stream against the model
    for (int i = 0; i < 4000; i++) begin
      {master_i, tx_mode_i, tx_empty_i, rx_full_i} = 4'($urandom);
      {ack_chk_en_i, wait_en_i, arb_irq_en_i, fmt_sel_i, stop_mask_i, irq_en_i} = 6'($urandom);
      {start_det_i, stop_det_i, tx_load_i, rx_load_i, ack_done_i, ack_bit_i} =
        6'($urandom) & 6'($urandom);
      {wait_ins_i, arb_lost_i, addr_frame_i, gen_call_i} = 4'($urandom) & 4'($urandom);
      addr_hit_i = N'($urandom);
      wr_en_i = ($urandom_range(0, 2) == 0);
      wr_data_i = 1'($urandom);
      cyc("RND");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule